// File: doc/BRIEF.md
# Delayed Masked Interrupt Controller

This block collects event bits from the datapath of a device and turns them into one host interrupt line. Each event source posts a bit vector that is ORed into a sticky status register. A mask register selects which status bits may interrupt, and a global enable gates the whole line. An assertion is scheduled after a programmable number of clock cycles, unless one of the posted effective bits is in the urgent group, which schedules it at once. Only one assertion is ever scheduled: a sooner request replaces it and a later one is dropped.

Two watermark events are gated by history. A receive-high event reaches the line only after a receive-empty condition was recorded. A transmit-low event reaches the line only after a transmit-full condition was recorded. Each recorded condition is used up by the next post of any kind. Software clears status by reading it or by writing ones. It can change the mask or the enable, and it can raise a soft event. Once the line is high it stays high until the status or mask leaves no effective bit, or until the enable is switched off.

Event bit encoding (bit index): 0 soft, 1 receive packet, 2 receive copy done, 3 receive high, 4 receive empty, 5 transmit packet, 6 transmit low, 7 reserved. The urgent (no-delay) group is bit 0.

Top module: `irq_delay_ctrl`

## Requirements
- R1: After reset, status is 0x00, mask is 0x4B (bits 0, 1, 3 and 6 set), enable is 0, and irq and err are 0.
- R2: A post ORs its bits into status one edge later. Bit 7 is reserved: it is never stored, and a post or a clear that carries bit 7 drives err high for the one cycle after that edge.
- R3: A post whose gated effective set (status AND mask) is nonzero, with enable high and no bit 0 in that set, schedules the line D+1 edges after the post edge, where D is delay_cfg sampled at the post. D = 0 means the line rises on the next edge.
- R4: A soft request (soft_req) posts bit 0. Because bit 0 is urgent, irq rises on the edge after the post, whatever delay_cfg holds.
- R5: Only the earliest deadline is kept. A request due sooner than the one scheduled replaces it. A request due later is ignored.
- R6: Bit 3 counts toward the effective set only if the receive-empty flag (set by rx_empty_set) is set when the post arrives. Any post consumes the flag.
- R7: Bit 6 is gated in the same way by the transmit-full flag, which is set by tx_full_set.
- R8: Bits outside the mask are stored in status but never schedule the line.
- R9: A status read clears all status. A clear writes ones to drop the matching bits. When status AND mask becomes zero, irq falls on that edge and any scheduled assertion is cancelled.
- R10: A mask write that changes the mask raises irq on the next edge if status AND new mask is nonzero. Otherwise it drops irq and cancels the schedule. Writing the same mask has no effect.
- R11: Turning enable off drops irq and cancels the schedule, and posts made while it is off schedule nothing. Turning it on with status AND mask nonzero raises irq on the next edge.
- R12: While irq is high, further posts and firing deadlines leave it high. Only the conditions of R9, R10 and R11 lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post post_bits this cycle |
| post_bits | input | 8 | Event bits to post |
| soft_req | input | 1 | Post the soft event (bit 0) |
| rx_empty_set | input | 1 | Record the receive-empty condition |
| tx_full_set | input | 1 | Record the transmit-full condition |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_bits | input | 8 | Status bits to clear |
| stat_rd | input | 1 | Status read; clears status |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask |
| en_wr | input | 1 | Global enable write strobe |
| en_wdata | input | 1 | New global enable |
| delay_cfg | input | DELAY_W | Assertion delay in cycles |
| status_q | output | 8 | Status register |
| mask_q | output | 8 | Mask register |
| en_q | output | 1 | Global enable |
| irq | output | 1 | Host interrupt line (pending) |
| err_q | output | 1 | Reserved-bit misuse, one cycle |

## Verification
The bench counts edges to the exact cycle the line rises after a delayed post and after an urgent post. A counter that is off by one would make irq rise one cycle early or one cycle late. It checks that a soft post shortens a running delay, and that a longer delay posted later does not extend it. A design that always replaced the deadline, or never replaced it, would move the rising edge. The watermark gating is exercised with the history flag clear, with it set, and again after the flag has been used up. A design that ignored the flag or never consumed it would assert the line in the wrong cases. Mask and enable writes are checked for their immediate effect on the line, including a disabled window in which posts must stay silent.

// File: rtl/irq_delay_pkg.sv
package irq_delay_pkg;
  localparam int EVT_W = 8;
  typedef logic [EVT_W-1:0] evt_t;

  localparam int B_SOFT    = 0;
  localparam int B_RXPKT   = 1;
  localparam int B_RXDMA   = 2;
  localparam int B_RXHIGH  = 3;
  localparam int B_RXEMPTY = 4;
  localparam int B_TXPKT   = 5;
  localparam int B_TXLOW   = 6;
  localparam int B_RESV    = 7;

  function automatic evt_t bit_of(int idx);
    return evt_t'(1) << idx;
  endfunction

  function automatic evt_t effective(evt_t st, evt_t msk);
    return st & msk;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_delay_pkg::*;
#(
  parameter int HIGH_BIT = B_RXHIGH,
  parameter int LOW_BIT  = B_TXLOW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_any,
  input  logic             rx_empty_set,
  input  logic             tx_full_set,
  input  logic [EVT_W-1:0] eff_in,
  output logic [EVT_W-1:0] eff_out
);
  logic rx_armed, tx_armed;

  always_comb begin
    eff_out = eff_in;
    if (!rx_armed) eff_out[HIGH_BIT] = 1'b0;
    if (!tx_armed) eff_out[LOW_BIT]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_armed <= 1'b0;
      tx_armed <= 1'b0;
    end else begin
      if (rx_empty_set)  rx_armed <= 1'b1;
      else if (post_any) rx_armed <= 1'b0;
      if (tx_full_set)   tx_armed <= 1'b1;
      else if (post_any) tx_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_sched.sv
module irq_sched #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [DELAY_W-1:0] req_delay,
  input  logic               cancel,
  output logic               pending,
  output logic               fire_now
);
  logic               armed_q, armed_n;
  logic [DELAY_W-1:0] cnt_q, cnt_n;
  logic               pend_n;

  function automatic logic takes_over(logic have, logic [DELAY_W-1:0] cur,
                                      logic [DELAY_W-1:0] want);
    return !have || (want < cur);
  endfunction

  always_comb begin
    armed_n  = armed_q;
    cnt_n    = cnt_q;
    pend_n   = pending;
    fire_now = 1'b0;
    if (armed_q) begin
      if (cnt_q == '0) begin
        fire_now = 1'b1;
        armed_n  = 1'b0;
        pend_n   = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
    if (req_valid && takes_over(armed_n, cnt_n, req_delay)) begin
      armed_n = 1'b1;
      cnt_n   = req_delay;
    end
    if (cancel) begin
      armed_n = 1'b0;
      pend_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      pending <= pend_n;
    end
  end
endmodule

// File: rtl/irq_delay_ctrl.sv
module irq_delay_ctrl
  import irq_delay_pkg::*;
#(
  parameter int   DELAY_W      = 8,
  parameter evt_t NODELAY_MASK = 8'h01,
  parameter evt_t RESV_MASK    = 8'h80,
  parameter evt_t MASK_RST     = 8'h4B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [EVT_W-1:0]   post_bits,
  input  logic               soft_req,
  input  logic               rx_empty_set,
  input  logic               tx_full_set,
  input  logic               clr_valid,
  input  logic [EVT_W-1:0]   clr_bits,
  input  logic               stat_rd,
  input  logic               mask_wr,
  input  logic [EVT_W-1:0]   mask_wdata,
  input  logic               en_wr,
  input  logic               en_wdata,
  input  logic [DELAY_W-1:0] delay_cfg,
  output logic [EVT_W-1:0]   status_q,
  output logic [EVT_W-1:0]   mask_q,
  output logic               en_q,
  output logic               irq,
  output logic               err_q
);
  localparam evt_t USABLE = ~RESV_MASK;

  evt_t post_vec, status_p, status_n, mask_n, clr_vec, eff_raw, eff_gated;
  logic post_any, clr_any, mask_chg, en_chg, en_n, bad_bits;
  logic post_req, mask_req, en_req, urgent, req_valid, cancel, fire_now;
  logic [DELAY_W-1:0] req_delay;

  assign post_any = post_valid | soft_req;
  assign post_vec = (post_valid ? post_bits : '0) | (soft_req ? bit_of(B_SOFT) : '0);
  assign clr_any  = clr_valid | stat_rd;
  assign clr_vec  = stat_rd ? USABLE : (clr_valid ? (clr_bits & USABLE) : '0);
  assign bad_bits = |(post_vec & RESV_MASK) | (clr_valid & |(clr_bits & RESV_MASK));

  assign mask_chg = mask_wr && (mask_wdata != mask_q);
  assign en_chg   = en_wr && (en_wdata != en_q);
  assign mask_n   = mask_chg ? mask_wdata : mask_q;
  assign en_n     = en_chg ? en_wdata : en_q;

  assign status_p = status_q | (post_vec & USABLE);
  assign status_n = status_p & ~clr_vec;
  assign eff_raw  = effective(status_p, mask_n);

  irq_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .post_any     (post_any),
    .rx_empty_set (rx_empty_set),
    .tx_full_set  (tx_full_set),
    .eff_in       (eff_raw),
    .eff_out      (eff_gated)
  );

  assign post_req  = post_any && |eff_gated;
  assign mask_req  = mask_chg && |effective(status_q, mask_n);
  assign en_req    = en_chg && en_wdata && |effective(status_q, mask_n);
  assign urgent    = mask_req || en_req || (post_req && |(eff_gated & NODELAY_MASK));
  assign req_valid = en_n && (post_req || mask_req || en_req);
  assign req_delay = urgent ? '0 : delay_cfg;
  assign cancel    = (clr_any && ~|effective(status_n, mask_n))
                   || (en_chg && !en_wdata)
                   || (mask_chg && ~|effective(status_q, mask_n));

  irq_sched #(.DELAY_W(DELAY_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_delay (req_delay),
    .cancel    (cancel),
    .pending   (irq),
    .fire_now  (fire_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      en_q     <= en_n;
      err_q    <= bad_bits;
    end
  end
endmodule

// File: rtl/irq_delay_chk.sv
module irq_delay_chk
  import irq_delay_pkg::*;
#(
  parameter evt_t RESV_MASK = 8'h80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic [EVT_W-1:0] status_q,
  input logic [EVT_W-1:0] mask_q,
  input logic             en_q,
  input logic             irq,
  input logic             fire_now,
  input logic             cancel
);
  AST_RESV_NEVER_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RESV_MASK) == '0); // R2
  AST_RISE_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire_now)); // R3
  AST_IRQ_NEEDS_EFFECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(status_q & mask_q)); // R9
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> status_q == '0); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q); // R11
  AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    fire_now && !cancel |=> irq); // R12
  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !cancel |=> irq); // R12
endmodule

bind irq_delay_ctrl irq_delay_chk #(.RESV_MASK(RESV_MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat_rd  (stat_rd),
  .status_q (status_q),
  .mask_q   (mask_q),
  .en_q     (en_q),
  .irq      (irq),
  .fire_now (fire_now),
  .cancel   (cancel)
);

// File: tb/irq_delay_ctrl_tb.sv
module irq_delay_ctrl_tb;
  typedef enum logic [3:0] {
    O_NOP, O_POST, O_SOFT, O_CLR, O_RD, O_MSK, O_EN, O_RXE, O_TXF
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] arg;
    logic [7:0] dly;
    logic [3:0] wt;
    logic [7:0] st;
    logic       irq;
    logic       err;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TBL [NV] = '{
    '{O_EN,   8'h01, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd11}, // R11 enable, nothing pending
    '{O_POST, 8'h02, 8'd4,  4'd4, 8'h02, 1'b0, 1'b0, 4'd3},  // R3 one edge before deadline
    '{O_NOP,  8'h00, 8'd4,  4'd0, 8'h02, 1'b1, 1'b0, 4'd3},  // R3 deadline reached
    '{O_RD,   8'h00, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 read clears
    '{O_SOFT, 8'h00, 8'd4,  4'd0, 8'h01, 1'b0, 1'b0, 4'd4},  // R4 soft post
    '{O_NOP,  8'h00, 8'd4,  4'd0, 8'h01, 1'b1, 1'b0, 4'd4},  // R4 urgent next edge
    '{O_CLR,  8'h01, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 w1c drops line
    '{O_POST, 8'h08, 8'd4,  4'd6, 8'h08, 1'b0, 1'b0, 4'd6},  // R6 rx-high without flag
    '{O_CLR,  8'h08, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_RXE,  8'h00, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 arm flag
    '{O_POST, 8'h08, 8'd4,  4'd5, 8'h08, 1'b1, 1'b0, 4'd6},  // R6 rx-high passes
    '{O_CLR,  8'h08, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h08, 8'd4,  4'd6, 8'h08, 1'b0, 1'b0, 4'd6},  // R6 flag consumed
    '{O_CLR,  8'h08, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h20, 8'd4,  4'd6, 8'h20, 1'b0, 1'b0, 4'd8},  // R8 unmasked bit
    '{O_MSK,  8'h6B, 8'd4,  4'd0, 8'h20, 1'b0, 1'b0, 4'd10}, // R10 unmask
    '{O_NOP,  8'h00, 8'd4,  4'd0, 8'h20, 1'b1, 1'b0, 4'd10}, // R10 line up next edge
    '{O_MSK,  8'h4B, 8'd4,  4'd0, 8'h20, 1'b0, 1'b0, 4'd10}, // R10 mask away drops
    '{O_MSK,  8'h4B, 8'd4,  4'd0, 8'h20, 1'b0, 1'b0, 4'd10}, // R10 same mask
    '{O_CLR,  8'h20, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h02, 8'd4,  4'd1, 8'h02, 1'b0, 1'b0, 4'd5},  // R5 delay running
    '{O_SOFT, 8'h00, 8'd4,  4'd0, 8'h03, 1'b0, 1'b0, 4'd5},  // R5 sooner replaces
    '{O_NOP,  8'h00, 8'd4,  4'd0, 8'h03, 1'b1, 1'b0, 4'd5},
    '{O_RD,   8'h00, 8'd4,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h02, 8'd4,  4'd0, 8'h02, 1'b0, 1'b0, 4'd5},  // R5 deadline 4
    '{O_POST, 8'h02, 8'd10, 4'd3, 8'h02, 1'b0, 1'b0, 4'd5},  // R5 later request ignored
    '{O_NOP,  8'h00, 8'd10, 4'd0, 8'h02, 1'b1, 1'b0, 4'd5},
    '{O_RD,   8'h00, 8'd0,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h02, 8'd0,  4'd1, 8'h02, 1'b1, 1'b0, 4'd3},  // R3 zero delay
    '{O_SOFT, 8'h00, 8'd0,  4'd1, 8'h03, 1'b1, 1'b0, 4'd12}, // R12 stays pending
    '{O_EN,   8'h00, 8'd0,  4'd0, 8'h03, 1'b0, 1'b0, 4'd11}, // R11 disable drops
    '{O_POST, 8'h02, 8'd0,  4'd3, 8'h03, 1'b0, 1'b0, 4'd11}, // R11 silent while off
    '{O_EN,   8'h01, 8'd0,  4'd1, 8'h03, 1'b1, 1'b0, 4'd11}, // R11 enable re-posts
    '{O_RD,   8'h00, 8'd0,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_POST, 8'h80, 8'd0,  4'd0, 8'h00, 1'b0, 1'b1, 4'd2},  // R2 reserved post
    '{O_CLR,  8'h80, 8'd0,  4'd0, 8'h00, 1'b0, 1'b1, 4'd2},  // R2 reserved clear
    '{O_POST, 8'h40, 8'd2,  4'd4, 8'h40, 1'b0, 1'b0, 4'd7},  // R7 tx-low without flag
    '{O_RD,   8'h00, 8'd2,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9},
    '{O_TXF,  8'h00, 8'd2,  4'd0, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 arm flag
    '{O_POST, 8'h40, 8'd2,  4'd3, 8'h40, 1'b1, 1'b0, 4'd7},  // R7 tx-low passes
    '{O_RD,   8'h00, 8'd2,  4'd0, 8'h00, 1'b0, 1'b0, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       post_valid = 1'b0, soft_req = 1'b0, rx_empty_set = 1'b0, tx_full_set = 1'b0;
  logic       clr_valid = 1'b0, stat_rd = 1'b0, mask_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0;
  logic [7:0] post_bits = '0, clr_bits = '0, mask_wdata = '0, delay_cfg = '0;
  logic [7:0] status_q, mask_q;
  logic       en_q, irq, err_q;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_delay_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_bits(post_bits),
    .soft_req(soft_req), .rx_empty_set(rx_empty_set), .tx_full_set(tx_full_set),
    .clr_valid(clr_valid), .clr_bits(clr_bits), .stat_rd(stat_rd),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .delay_cfg(delay_cfg), .status_q(status_q), .mask_q(mask_q), .en_q(en_q),
    .irq(irq), .err_q(err_q)
  );

  task automatic check(string what, int req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_vec(vec_t v, int idx);
    delay_cfg = v.dly;
    case (v.op)
      O_POST: begin post_valid = 1'b1; post_bits = v.arg; end
      O_SOFT: soft_req = 1'b1;
      O_CLR:  begin clr_valid = 1'b1; clr_bits = v.arg; end
      O_RD:   stat_rd = 1'b1;
      O_MSK:  begin mask_wr = 1'b1; mask_wdata = v.arg; end
      O_EN:   begin en_wr = 1'b1; en_wdata = v.arg[0]; end
      O_RXE:  rx_empty_set = 1'b1;
      O_TXF:  tx_full_set = 1'b1;
      default: ;
    endcase
    tick();
    post_valid = 1'b0; soft_req = 1'b0; clr_valid = 1'b0; stat_rd = 1'b0;
    mask_wr = 1'b0; en_wr = 1'b0; rx_empty_set = 1'b0; tx_full_set = 1'b0;
    for (int w = 0; w < int'(v.wt); w++) tick();
    check($sformatf("vec %0d status", idx), int'(v.req), status_q, v.st);
    check($sformatf("vec %0d irq", idx), int'(v.req), {7'b0, irq}, {7'b0, v.irq});
    check($sformatf("vec %0d err", idx), int'(v.req), {7'b0, err_q}, {7'b0, v.err});
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("reset status", 1, status_q, 8'h00);
    check("reset mask", 1, mask_q, 8'h4B);
    check("reset enable", 1, {7'b0, en_q}, 8'h00);
    check("reset irq", 1, {7'b0, irq}, 8'h00);
    check("reset err", 1, {7'b0, err_q}, 8'h00);
    rst_n = 1'b1;
    tick();
    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);
    // R10 mask value after the rewrite sequence
    check("mask after writes", 10, mask_q, 8'h4B);
    // R1 reset in mid-operation returns to defaults
    run_vec('{O_POST, 8'h02, 8'd6, 4'd1, 8'h02, 1'b0, 1'b0, 4'd3}, NV);
    rst_n = 1'b0;
    tick();
    check("re-reset status", 1, status_q, 8'h00);
    check("re-reset enable", 1, {7'b0, en_q}, 8'h00);
    rst_n = 1'b1;
    repeat (8) tick();
    check("re-reset irq stays low", 1, {7'b0, irq}, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule